// File: doc/BRIEF.md
# Rewindable Word Queue with Half-Level Flag

This block is a single-clock first-in/first-out queue of 9-bit words. Words go into an internal storage array at a circular write location and come out of it in arrival order from a circular read location. Neither location is ever given from outside. A producer pulses `wr_req` with a word on `wr_data`. A consumer pulses `rd_req` and receives the oldest word on `rd_data` one cycle later, marked by a one-cycle `rd_valid` pulse. Three registered status outputs give the fill state: `empty`, `full`, and `half_full`, which means more than half the capacity is occupied.

A low level on `rewind_n` moves only the read location back to location zero and leaves the write location where it is. The words written since the last reset can then be delivered again from the start. The flags are recomputed from the new distance between the two locations. Rewind and reset are meant to be applied while both request inputs are idle. Any request that arrives during either of them is dropped.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both locations return to zero. After that edge `empty` is 1, and `full`, `half_full` and `rd_valid` are 0.
- R2: Words come out in the order they were written. An accepted read drives the word on `rd_data`, with `rd_valid` high, in the cycle after the edge that accepted it. `rd_valid` is low in every cycle that does not follow an accepted read.
- R3: With no reads after reset, `full` rises after exactly DEPTH accepted writes. A write request while `full` is high and no read is accepted in the same cycle is dropped and changes no stored word.
- R4: A read request while `empty` is high is dropped. It produces no `rd_valid` pulse and does not move the read location.
- R5: `half_full` rises on the write that takes the stored count above DEPTH/2. It falls on the read that brings the count back to DEPTH/2.
- R6: When neither is blocked, a read and a write in the same cycle are both accepted, and the flags keep their values.
- R7: While `full` is high, a read and a write in the same cycle are both accepted. The read returns the oldest word, and `full` stays high.
- R8: While `empty` is high, a read and a write in the same cycle accept only the write. `empty` falls, and the new word is delivered by a later read.
- R9: A rewind (`rewind_n` low) sets the read location to zero and keeps the write location. The stored count becomes the write location index, so `half_full` and `empty` follow the new count. Later reads restart from the first word written after reset.
- R10: Read and write requests that coincide with a rewind or a reset are ignored.
- R11: An accepted write clears `empty` and an accepted read clears `full`, both at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every request is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to be stored |
| rd_req | input | 1 | Read request for this cycle |
| rewind_n | input | 1 | Active-low rewind of the read location to zero |
| rd_data | output | 9 | Word delivered by the previous accepted read |
| rd_valid | output | 1 | One-cycle pulse qualifying `rd_data` |
| empty | output | 1 | No unread word is stored |
| full | output | 1 | DEPTH unread words are stored |
| half_full | output | 1 | More than DEPTH/2 unread words are stored |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a read with a write at either fill boundary. The second pair is a rewind with pending requests. Each boundary is reached in turn: the queue is filled to capacity and then given a read and a write together, and it is drained to empty and then given a write and a read together. The result is judged by whether `full` stays set and the oldest word comes out, or whether the read is refused and `empty` falls. For the rewind, both requests are held high during the rewind cycle. The ignored write is then shown absent by draining the queue, and the ignored read by the missing `rd_valid` pulse.

// File: rtl/rfifo_pkg.sv
// Shared definitions for the rewindable queue.
// Assumes: nothing beyond the standard language.
package rfifo_pkg;

    // Kind of level change the current cycle brings about
    typedef enum logic [1:0] {
        LV_HOLD = 2'b00,
        LV_PUSH = 2'b01,
        LV_POP  = 2'b10,
        LV_BOTH = 2'b11
    } level_op_t;

    // Classifies accepted push/pop into a level change
    function automatic level_op_t classify(input logic push, input logic pop);
        return level_op_t'({pop, push});
    endfunction

endpackage

// File: rtl/rfifo_ptr.sv
// Circular location counter.
// Clears on reset or on a zero request. Otherwise it advances by one when
// told to, wrapping naturally because the depth is a power of two.
module rfifo_ptr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero,
    input  logic          adv,
    output logic [AW-1:0] loc
);

    // Location register: reset/zero take priority over advance
    always_ff @(posedge clk) begin
        if (!rst_n || zero)
            loc <= '0;
        else if (adv)
            loc <= loc + AW'(1);
    end

endmodule

// File: rtl/rfifo_level.sv
// Fill level and status flags.
// Keeps the unread count and registers empty/full/half_full from the next
// count, so each flag changes at the edge that accepts the causing request.
// On rewind the count becomes the write location index. This assumes fewer
// than DEPTH writes since reset, so a wrapped write location is not expected.
module rfifo_level
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          rewind,
    input  logic [AW-1:0] wr_loc,
    output logic          empty,
    output logic          full,
    output logic          half_full
);

    localparam int            CW       = AW + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

    logic [CW-1:0] count;
    logic [CW-1:0] count_nx;

    // Next count from rewind or the accepted push/pop combination
    always_comb begin
        count_nx = count;
        if (rewind) begin
            count_nx = {1'b0, wr_loc};
        end else begin
            unique case (classify(push, pop))
                LV_PUSH: count_nx = count + CW'(1);
                LV_POP:  count_nx = count - CW'(1);
                default: count_nx = count;
            endcase
        end
    end

    // Count and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            empty     <= 1'b1;
            full      <= 1'b0;
            half_full <= 1'b0;
        end else begin
            count     <= count_nx;
            empty     <= (count_nx == '0);
            full      <= (count_nx == FULL_LVL);
            half_full <= (count_nx > HALF_LVL);
        end
    end

endmodule

// File: rtl/rfifo_store.sv
// Word storage with a registered read port.
// A write stores at waddr. A read captures the word at raddr before any write
// in the same cycle lands, and raises rvalid for one cycle. The array itself
// is not reset; only the output register and valid bit are.
module rfifo_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic [DW-1:0] mem [DEPTH];

    // Array write
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read data and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re)
                rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/replay_fifo.sv
// Rewindable first-in/first-out queue with a half-level flag (top).
// Gates the requests against the flags: a read is refused when the queue is
// empty, and a write when it is full unless a read is accepted in the same
// cycle. Reset and rewind drop any coinciding request.
// Assumes: DEPTH is a power of two, at least 4.
module replay_fifo #(
    parameter int DW    = 9,
    parameter int DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rewind_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          empty,
    output logic          full,
    output logic          half_full
);

    localparam int AW = $clog2(DEPTH);

    logic          live;
    logic          pop;
    logic          push;
    logic          rewind;
    logic [AW-1:0] wr_loc;
    logic [AW-1:0] rd_loc;

    // Request acceptance against the flags
    always_comb begin
        live   = rst_n && rewind_n;
        rewind = rst_n && !rewind_n;
        pop    = live && rd_req && !empty;
        push   = live && wr_req && (!full || pop);
    end

    rfifo_ptr #(.AW(AW)) wr_ptr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .zero (1'b0),
        .adv  (push),
        .loc  (wr_loc)
    );

    rfifo_ptr #(.AW(AW)) rd_ptr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .zero (rewind),
        .adv  (pop),
        .loc  (rd_loc)
    );

    rfifo_level #(.DEPTH(DEPTH), .AW(AW)) level_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .rewind   (rewind),
        .wr_loc   (wr_loc),
        .empty    (empty),
        .full     (full),
        .half_full(half_full)
    );

    rfifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push),
        .waddr (wr_loc),
        .wdata (wr_data),
        .re    (pop),
        .raddr (rd_loc),
        .rdata (rd_data),
        .rvalid(rd_valid)
    );

endmodule

// File: rtl/rfifo_chk.sv
// Port-level temporal checks for replay_fifo, attached by bind.
module rfifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_req,
    input logic rd_req,
    input logic rewind_n,
    input logic rd_valid,
    input logic empty,
    input logic full,
    input logic half_full
);

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req) |=> !rd_valid);

    // R2
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !empty && rewind_n) |=> rd_valid);

    // R2
    idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R7
    full_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && rd_req && rewind_n) |=> full);

    // R11
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_req && !wr_req && rewind_n) |=> !full);

    // R10
    rewind_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> !rd_valid);

    // R5
    half_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_full) |-> ($past(wr_req) || !$past(rewind_n)));

endmodule

bind replay_fifo rfifo_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .rewind_n (rewind_n),
    .rd_valid (rd_valid),
    .empty    (empty),
    .full     (full),
    .half_full(half_full)
);

// File: tb/replay_fifo_tb_top.sv
`timescale 1ns/1ps
module replay_fifo_tb_top;

    localparam int D  = 16;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_req;
    logic [DW-1:0] wr_data;
    logic          rd_req;
    logic          rewind_n;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          empty;
    logic          full;
    logic          half_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    replay_fifo #(.DW(DW), .DEPTH(D)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rewind_n (rewind_n),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .empty    (empty),
        .full     (full),
        .half_full(half_full)
    );

    // Vector: [23]wr [22]rd [21:13]din [12]exp_valid [11:3]exp_data
    //         [2]exp_empty [1]exp_full [0]exp_half  (state after the edge)
    localparam logic [23:0] VEC [0:7] = '{
        {1'b1, 1'b0, 9'h101, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 9'h0A2, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 9'h033, 1'b1, 9'h101, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 9'h000, 1'b1, 9'h0A2, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 9'h000, 1'b1, 9'h033, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b1, 9'h1FF, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 9'h000, 1'b1, 9'h1FF, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then sample after the next falling edge
    task automatic cyc(input logic w, input logic r, input logic rw_n, input logic [DW-1:0] d);
        wr_req   = w;
        rd_req   = r;
        rewind_n = rw_n;
        wr_data  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, '0);
        cyc(1'b0, 1'b0, 1'b1, '0);
        rst_n = 1'b1;
    endtask

    task automatic flags(input string tag, input logic e, input logic f, input logic h);
        chk({tag, " empty"}, DW'(empty), DW'(e));
        chk({tag, " full"}, DW'(full), DW'(f));
        chk({tag, " half_full"}, DW'(half_full), DW'(h));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wr_req = 0; rd_req = 0; rewind_n = 1; wr_data = '0; rst_n = 0;
        @(negedge clk);

        // R10: requests held during reset are dropped; R1 reset state
        rst_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 9'h0EE);
        cyc(1'b1, 1'b1, 1'b1, 9'h0EE);
        rst_n = 1'b1;
        flags("R1", 1'b1, 1'b0, 1'b0);
        chk("R1 rd_valid", DW'(rd_valid), '0);
        cyc(1'b0, 1'b1, 1'b1, '0);
        chk("R10 read after reset", DW'(rd_valid), '0);
        chk("R10 still empty", DW'(empty), 9'd1);

        // Table walk: R2 order/valid, R6 concurrent, R4 empty read, R8 empty both, R11 clears
        foreach (VEC[i]) begin
            cyc(VEC[i][23], VEC[i][22], 1'b1, VEC[i][21:13]);
            chk($sformatf("R2/R6 vec%0d rd_valid", i), DW'(rd_valid), DW'(VEC[i][12]));
            if (VEC[i][12])
                chk($sformatf("R2 vec%0d rd_data", i), rd_data, VEC[i][11:3]);
            flags($sformatf("R4/R8/R11 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // Fill from reset: R5 half rise, R3 full after exactly D writes
        do_reset();
        for (int i = 0; i < D; i++) begin
            cyc(1'b1, 1'b0, 1'b1, DW'(9'h040 + i));
            flags($sformatf("R3/R5 fill %0d", i), 1'b0, (i == D - 1), ((i + 1) > D / 2));
        end
        // R3: write while full is dropped
        cyc(1'b1, 1'b0, 1'b1, 9'h1AA);
        chk("R3 full holds", DW'(full), 9'd1);
        // R7: read and write while full
        cyc(1'b1, 1'b1, 1'b1, 9'h155);
        chk("R7 rd_valid", DW'(rd_valid), 9'd1);
        chk("R7 oldest word", rd_data, 9'h040);
        chk("R7 full stays", DW'(full), 9'd1);
        // Drain: R3 dropped word absent, R5 half fall, R11 full clears
        for (int i = 0; i < D; i++) begin
            cyc(1'b0, 1'b1, 1'b1, '0);
            chk($sformatf("R3 drain %0d data", i), rd_data,
                (i < D - 1) ? DW'(9'h041 + i) : 9'h155);
            flags($sformatf("R5/R11 drain %0d", i), (i == D - 1), 1'b0, ((D - 1 - i) > D / 2));
        end

        // R9/R10: rewind replays from the first word, coinciding requests dropped
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b1, DW'(9'h010 + i));
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 1'b1, '0);
            chk("R2 pre-rewind data", rd_data, DW'(9'h010 + i));
        end
        cyc(1'b1, 1'b1, 1'b0, 9'h077);
        chk("R10 no read during rewind", DW'(rd_valid), '0);
        flags("R9 after rewind", 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 1'b1, '0);
            chk("R9 replay data", rd_data, DW'(9'h010 + i));
        end
        chk("R9 empty after replay", DW'(empty), 9'd1);
        cyc(1'b0, 1'b1, 1'b1, '0);
        chk("R10 rewind write dropped", DW'(rd_valid), '0);

        // R9: rewind raises half_full from the restored count
        do_reset();
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b1, DW'(i));
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1, '0);
        flags("R5 six left", 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '0);
        flags("R9 rewind half", 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, '0);
        chk("R9 rewind first word", rd_data, 9'h000);

        finish_run();
    end

endmodule